// File: doc/BRIEF.md
# Consecutive Split Response Checker

This block is a passive monitor for a shared bus. It watches completed transfers at one observation point and raises an error when a slave gives a master two split responses in a row. The block never drives the bus. It only takes in the transfer-complete strobe, the master ID of the finished transfer, the split status of its response and a target index.

The monitor keeps the master ID of the last transfer it counted. Any split response arms an obligation. The obligation stays pending until a later transfer comes from the same master as the transfer just before it. That transfer must not be a split, or a violation is recorded. The parameter `BUS_SIDE` picks where the monitor sits:

- At the slave itself (`BUS_SIDE = 0`), every completed transfer counts.
- On the bus initiator port (`BUS_SIDE = 1`), only transfers routed to target index 0, the split-capable memory, count. Transfers to other targets are skipped.

Each violation produces a one-cycle pulse, sets a sticky flag and increments a saturating counter. A synchronous clear input resets the flag and the counter.

Top module: `split_repeat_monitor`

## Requirements
- R1: During and after reset, `err_pulse`, `err_sticky` and `err_count` are 0. The master history holds a sentinel value of `2**MID_W`, which no real master ID can equal, and no obligation is pending.
- R2: A transfer is qualifying when it completes and, in bus-side mode, is routed to the split-capable memory (see R6). If a qualifying transfer has a split response while an obligation is pending, and its master equals the master of the previous qualifying transfer, then `err_pulse` is 1 in the cycle after that transfer. `err_sticky` is also set in that cycle.
- R3: A qualifying non-split transfer never raises an error. If its master matches the previous one, it discharges the pending obligation.
- R4: A qualifying transfer whose master differs from the previous master neither checks nor discharges the obligation. If it carries a split, the obligation is armed or stays armed.
- R5: In a cycle where `xfer_done` is 0, `xfer_split` and `xfer_mid` have no effect. The split status counts as false in such a cycle.
- R6: With `BUS_SIDE = 1`, only transfers with `xfer_tgt == 0` update the history or the obligation. With `BUS_SIDE = 0`, `xfer_tgt` is ignored.
- R7: `err_sticky` stays at 1 until `clr` is high for a cycle. `clr` sets `err_sticky` and `err_count` to 0 but leaves the history and any pending obligation as they are.
- R8: If a violation and `clr` fall in the same cycle, the violation wins. The next cycle shows `err_sticky = 1` and `err_count = 1`.
- R9: `err_count` increments by one for each violation and holds at `2**CNT_W - 1`.
- R10: `err_pulse` lasts exactly one cycle for each violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of the error flag and the counter |
| xfer_done | input | 1 | A transfer completes in this cycle |
| xfer_mid | input | MID_W | Master ID of the completing transfer |
| xfer_split | input | 1 | The completing transfer's response is a split |
| xfer_tgt | input | TGT_W | Target index of the completing transfer (0 is the split-capable memory) |
| err_sticky | output | 1 | Sticky violation flag |
| err_pulse | output | 1 | One-cycle violation pulse |
| err_count | output | CNT_W | Saturating violation counter |

## Verification
The bound checker runs these checks on every cycle:
- Reset leaves the outputs clean.
- An idle cycle, a non-split transfer or a transfer to another target in bus-side mode never produces a pulse.
- Every pulse comes with the sticky flag.
- The flag holds until a clear.
- A saturated counter stays saturated.

The history-dependent rules cannot be written as single-cycle properties. The bench scenarios cover them:
- An obligation that waits through transfers from other masters.
- Discharge by a matching non-split transfer.
- Skipped targets that leave the history untouched.
- A clear that keeps a pending obligation.
- A clear that coincides with a violation.

// File: rtl/split_repeat_monitor.sv
module split_repeat_monitor #(
  parameter int MID_W    = 4,
  parameter int TGT_W    = 2,
  parameter int BUS_SIDE = 1,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             xfer_done,
  input  logic [MID_W-1:0] xfer_mid,
  input  logic             xfer_split,
  input  logic [TGT_W-1:0] xfer_tgt,
  output logic             err_sticky,
  output logic             err_pulse,
  output logic [CNT_W-1:0] err_count
);
  localparam int HW = MID_W + 1;
  localparam logic [HW-1:0]    NO_MASTER = {1'b1, {MID_W{1'b0}}};
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  logic [HW-1:0] last_mid_q;
  logic          pend_q;
  logic          tgt_ok;

  generate
    if (BUS_SIDE != 0) begin : g_bus
      assign tgt_ok = (xfer_tgt == '0);
    end else begin : g_slave
      assign tgt_ok = 1'b1;
    end
  endgenerate

  wire qual        = xfer_done && tgt_ok;
  wire split_now   = qual && xfer_split;
  wire same_master = qual && ({1'b0, xfer_mid} == last_mid_q);
  wire violation   = same_master && pend_q && split_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_mid_q <= NO_MASTER;
      pend_q     <= 1'b0;
    end else if (qual) begin
      last_mid_q <= {1'b0, xfer_mid};
      pend_q     <= split_now || (pend_q && !same_master);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse  <= 1'b0;
      err_sticky <= 1'b0;
      err_count  <= '0;
    end else begin
      err_pulse  <= violation;
      err_sticky <= violation || (err_sticky && !clr);
      if (clr)
        err_count <= violation ? CNT_W'(1) : '0;
      else if (violation && err_count != CNT_MAX)
        err_count <= err_count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/split_repeat_monitor_chk.sv
module split_repeat_monitor_chk #(
  parameter int MID_W    = 4,
  parameter int TGT_W    = 2,
  parameter int BUS_SIDE = 1,
  parameter int CNT_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             xfer_done,
  input logic [MID_W-1:0] xfer_mid,
  input logic             xfer_split,
  input logic [TGT_W-1:0] xfer_tgt,
  input logic             err_sticky,
  input logic             err_pulse,
  input logic [CNT_W-1:0] err_count
);
  // R1
  reset_clean_chk: assert property (@(posedge clk)
    !rst_n |=> (!err_sticky && !err_pulse && err_count == '0));

  // R2
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);

  // R3
  nonsplit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !xfer_split) |=> !err_pulse);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_done |=> !err_pulse);

  // R6
  foreign_target_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((BUS_SIDE != 0) && xfer_done && xfer_tgt != '0) |=> !err_pulse);

  // R7
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !clr) |=> err_sticky);

  // R9
  count_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&err_count) && !clr) |=> (&err_count));

  wire unused_ok = ^xfer_mid;
endmodule

bind split_repeat_monitor split_repeat_monitor_chk #(
  .MID_W(MID_W), .TGT_W(TGT_W), .BUS_SIDE(BUS_SIDE), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .xfer_done(xfer_done),
  .xfer_mid(xfer_mid), .xfer_split(xfer_split), .xfer_tgt(xfer_tgt),
  .err_sticky(err_sticky), .err_pulse(err_pulse), .err_count(err_count)
);

// File: tb/tb_split_repeat_monitor.sv
module tb_split_repeat_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       done = 1'b0;
  logic [3:0] mid = '0;
  logic       spl = 1'b0;
  logic [1:0] tgt = '0;

  logic       st_b, pu_b, st_s, pu_s;
  logic [7:0] cnt_b;
  logic [1:0] cnt_s;

  int checks = 0, fails = 0;
  int ecnt_b = 0, ecnt_s = 0;
  bit est_b = 0, est_s = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  split_repeat_monitor #(.MID_W(4), .TGT_W(2), .BUS_SIDE(1), .CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .xfer_done(done), .xfer_mid(mid),
    .xfer_split(spl), .xfer_tgt(tgt), .err_sticky(st_b), .err_pulse(pu_b),
    .err_count(cnt_b));

  split_repeat_monitor #(.MID_W(4), .TGT_W(2), .BUS_SIDE(0), .CNT_W(2)) dut_slv (
    .clk(clk), .rst_n(rst_n), .clr(clr), .xfer_done(done), .xfer_mid(mid),
    .xfer_split(spl), .xfer_tgt(tgt), .err_sticky(st_s), .err_pulse(pu_s),
    .err_count(cnt_s));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input bit eb, input bit es);
    chk(req, "bus pulse", pu_b, eb);
    chk(req, "slave pulse", pu_s, es);
    chk(req, "bus flag", st_b, est_b);
    chk(req, "slave flag", st_s, est_s);
    chk(req, "bus count", cnt_b, ecnt_b);
    chk(req, "slave count", cnt_s, ecnt_s);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    est_b = 0; est_s = 0; ecnt_b = 0; ecnt_s = 0;
  endtask

  task automatic xfer(input string req, input logic [3:0] m, input bit s,
                      input logic [1:0] t, input bit c, input bit eb, input bit es);
    done = 1'b1; mid = m; spl = s; tgt = t; clr = c;
    @(negedge clk);
    done = 1'b0; spl = 1'b0; clr = 1'b0;
    if (c) begin
      est_b = eb; est_s = es;
      ecnt_b = eb; ecnt_s = es;
    end else begin
      est_b = est_b | eb; est_s = est_s | es;
      if (eb && ecnt_b < 255) ecnt_b++;
      if (es && ecnt_s < 3) ecnt_s++;
    end
    check_all(req, eb, es);
  endtask

  task automatic t_reset();
    do_reset();
    check_all("R1", 0, 0);
    xfer("R1", 4'hF, 1, 0, 0, 0, 0);
  endtask

  task automatic t_repeat();
    do_reset();
    xfer("R2", 3, 1, 0, 0, 0, 0);
    xfer("R2", 3, 1, 0, 0, 1, 1);
    @(negedge clk);
    check_all("R10", 0, 0);
  endtask

  task automatic t_discharge();
    do_reset();
    xfer("R3", 5, 1, 0, 0, 0, 0);
    xfer("R3", 5, 0, 0, 0, 0, 0);
    xfer("R3", 5, 1, 0, 0, 0, 0);
    xfer("R3", 5, 0, 0, 0, 0, 0);
  endtask

  task automatic t_interleave();
    do_reset();
    xfer("R4", 1, 1, 0, 0, 0, 0);
    xfer("R4", 2, 1, 0, 0, 0, 0);
    xfer("R4", 2, 1, 0, 0, 1, 1);
    do_reset();
    xfer("R4", 1, 1, 0, 0, 0, 0);
    xfer("R4", 2, 0, 0, 0, 0, 0);
    xfer("R4", 1, 1, 0, 0, 0, 0);
    xfer("R4", 1, 1, 0, 0, 1, 1);
  endtask

  task automatic t_idle();
    do_reset();
    xfer("R5", 4, 1, 0, 0, 0, 0);
    mid = 4; spl = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_all("R5", 0, 0);
    end
    spl = 1'b0;
    xfer("R5", 4, 0, 0, 0, 0, 0);
    xfer("R5", 4, 1, 0, 0, 0, 0);
  endtask

  task automatic t_target();
    do_reset();
    xfer("R6", 6, 1, 0, 0, 0, 0);
    xfer("R6", 7, 1, 2, 0, 0, 0);
    xfer("R6", 6, 1, 0, 0, 1, 0);
    xfer("R6", 6, 0, 0, 0, 0, 0);
  endtask

  task automatic t_clear();
    do_reset();
    xfer("R7", 8, 1, 0, 0, 0, 0);
    xfer("R7", 8, 1, 0, 0, 1, 1);
    @(negedge clk);
    check_all("R7", 0, 0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    est_b = 0; est_s = 0; ecnt_b = 0; ecnt_s = 0;
    check_all("R7", 0, 0);
    xfer("R7", 8, 1, 0, 0, 1, 1);
    xfer("R8", 8, 1, 0, 1, 1, 1);
    xfer("R8", 9, 0, 0, 1, 0, 0);
  endtask

  task automatic t_saturate();
    do_reset();
    xfer("R9", 9, 1, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) xfer("R9", 9, 1, 0, 0, 1, 1);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    t_reset();
    t_repeat();
    t_discharge();
    t_interleave();
    t_idle();
    t_target();
    t_clear();
    t_saturate();
    finished = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end
endmodule